// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block turns a 24-bit virtual address into a 32-bit physical address in the same cycle as the request. It holds a set of translation entries. Each entry has a virtual page number, a physical frame number, a process identifier and four flags: valid, writable, referenced and dirty. Every lookup compares the page number against all entries at once. The block never walks memory. A lookup that finds no usable entry raises a miss, and software then loads the mapping through a refill port, naming the slot to overwrite.

Stale mappings from a previous process can be removed in two ways. A flush input clears every valid flag in one cycle. When process tagging is enabled, a hit also needs the entry's process identifier to equal the current one. A write to a page whose writable flag is clear raises a protection fault and does not hit. Hits record use in the referenced flag, and write hits also set the dirty flag. On a hit the entry's stored flags are presented at the lookup port, so software can see them.

Top module: `tlb_fa`

## Requirements
- R1: On a hit, lk_paddr[31:13] is the entry's frame number and lk_paddr[12:0] equals lk_vaddr[12:0]. lk_paddr is zero when there is no hit.
- R2: A lookup hits when some entry is valid and its page number equals lk_vaddr[23:13]. The result appears combinationally in the cycle of the request.
- R3: When several entries match, the entry with the lowest index supplies the translation.
- R4: With pid_tag_en high, an entry matches only if its stored process ID equals cur_pid. With pid_tag_en low, the process ID is ignored.
- R5: A valid lookup that matches no entry drives lk_miss high, with lk_hit and lk_prot low.
- R6: With rf_en high, the slot rf_idx is overwritten in full at the clock edge. The new contents are visible from the next cycle. A lookup in the same cycle still sees the old contents. A refill overrides any flag update that a same-cycle hit makes to that slot.
- R7: flush clears the valid flag of every entry at one clock edge. A refill in the same cycle still leaves its slot valid with the refilled contents.
- R8: A write lookup (lk_write=1) whose matching entry has writable clear drives lk_prot high and lk_hit low, and it changes no flag.
- R9: A hit sets the entry's referenced flag, and a write hit also sets its dirty flag. lk_ref and lk_dirty show the entry's flags as they stood before the cycle's update, and they read zero without a hit.
- R10: With lk_valid low, lk_hit, lk_miss and lk_prot are all low and no entry flag changes.
- R11: After reset every entry is invalid, so any lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 24 | Virtual address |
| lk_write | input | 1 | Access is a write |
| cur_pid | input | 8 | Current process ID |
| pid_tag_en | input | 1 | Require process ID match |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No matching entry (miss fault) |
| lk_prot | output | 1 | Write to a non-writable page |
| lk_paddr | output | 32 | Physical address |
| lk_ref | output | 1 | Referenced flag of the hit entry |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| rf_en | input | 1 | Refill write enable |
| rf_idx | input | 6 | Slot to overwrite |
| rf_vpn | input | 11 | Refill page number |
| rf_frame | input | 19 | Refill frame number |
| rf_pid | input | 8 | Refill process ID |
| rf_dirty | input | 1 | Refill dirty flag |
| rf_ref | input | 1 | Refill referenced flag |
| rf_wr | input | 1 | Refill writable flag |
| rf_valid | input | 1 | Refill valid flag |
| flush | input | 1 | Clear all valid flags |

## Verification
A hit's flag update, a refill and a flush can all land on the same clock edge. The bench forces these overlaps: a write hit together with a refill of the same slot, and a flush together with a refill. A later lookup then shows which value won through lk_hit, lk_paddr, lk_ref and lk_dirty. A free-running phase mixes random lookups, refills and flushes, and a behavioural model of the entry table checks each cycle's outputs.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    localparam int VA_W  = 24;
    localparam int PA_W  = 32;
    localparam int OFF_W = 13;
    localparam int PID_W = 8;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int FRM_W = PA_W - OFF_W;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [FRM_W-1:0] frame;
        logic [PID_W-1:0] pid;
        logic             dirty;
        logic             refd;
        logic             wr;
        logic             vld;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = 64
) (
    input  logic [NUM_ENT-1:0]            vld_vec,
    input  logic [NUM_ENT-1:0][VPN_W-1:0] vpn_vec,
    input  logic [NUM_ENT-1:0][PID_W-1:0] pid_vec,
    input  logic [VPN_W-1:0]              key_vpn,
    input  logic [PID_W-1:0]              key_pid,
    input  logic                          tag_en,
    output logic [NUM_ENT-1:0]            match_vec
);
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
        logic pid_ok;
        assign pid_ok       = !tag_en || (pid_vec[i] == key_pid);
        assign match_vec[i] = vld_vec[i] && (vpn_vec[i] == key_vpn) && pid_ok;
    end
endmodule

// File: rtl/tlb_prio.sv
`timescale 1ns/1ps
module tlb_prio #(
    parameter int NUM_ENT = 64,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic [NUM_ENT-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_store.sv
`timescale 1ns/1ps
module tlb_store
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = 64,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          upd_en,
    input  logic [IDX_W-1:0]              upd_idx,
    input  logic                          upd_write,
    input  logic                          flush,
    input  logic                          rf_en,
    input  logic [IDX_W-1:0]              rf_idx,
    input  tlb_entry_t                    rf_data,
    output tlb_entry_t [NUM_ENT-1:0]      ents
);
    typedef struct packed {
        tlb_entry_t [NUM_ENT-1:0] ent;
    } store_t;

    store_t st_d, st_q;
    logic [NUM_ENT-1:0] vld_now;

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.ent[upd_idx].refd = 1'b1;
            if (upd_write) st_d.ent[upd_idx].dirty = 1'b1;
        end
        if (flush) begin
            for (int i = 0; i < NUM_ENT; i++) st_d.ent[i].vld = 1'b0;
        end
        if (rf_en) st_d.ent[rf_idx] = rf_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ents = st_q.ent;

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) vld_now[i] = st_q.ent[i].vld;
    end

    assert_refill_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en |=> (st_q.ent[$past(rf_idx)] == $past(rf_data)));

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !rf_en) |=> (vld_now == '0));

    assert_ref_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !(rf_en && rf_idx == upd_idx)) |=> st_q.ent[$past(upd_idx)].refd);

    assert_dirty_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_write && !(rf_en && rf_idx == upd_idx)) |=> st_q.ent[$past(upd_idx)].dirty);
endmodule

// File: rtl/tlb_fa.sv
`timescale 1ns/1ps
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = 64,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic [PID_W-1:0] cur_pid,
    input  logic             pid_tag_en,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_prot,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_ref,
    output logic             lk_dirty,
    input  logic             rf_en,
    input  logic [IDX_W-1:0] rf_idx,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [FRM_W-1:0] rf_frame,
    input  logic [PID_W-1:0] rf_pid,
    input  logic             rf_dirty,
    input  logic             rf_ref,
    input  logic             rf_wr,
    input  logic             rf_valid,
    input  logic             flush
);
    tlb_entry_t [NUM_ENT-1:0]  ents;
    tlb_entry_t                rf_data;
    logic [NUM_ENT-1:0]        vld_vec;
    logic [NUM_ENT-1:0][VPN_W-1:0] vpn_vec;
    logic [NUM_ENT-1:0][PID_W-1:0] pid_vec;
    logic [NUM_ENT-1:0]        match_vec;
    logic                      found;
    logic [IDX_W-1:0]          sel_idx;
    tlb_entry_t                sel;
    logic                      hit_int;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_split
        assign vld_vec[i] = ents[i].vld;
        assign vpn_vec[i] = ents[i].vpn;
        assign pid_vec[i] = ents[i].pid;
    end

    always_comb begin
        rf_data       = '0;
        rf_data.vpn   = rf_vpn;
        rf_data.frame = rf_frame;
        rf_data.pid   = rf_pid;
        rf_data.dirty = rf_dirty;
        rf_data.refd  = rf_ref;
        rf_data.wr    = rf_wr;
        rf_data.vld   = rf_valid;
    end

    tlb_match #(.NUM_ENT(NUM_ENT)) u_match (
        .vld_vec  (vld_vec),
        .vpn_vec  (vpn_vec),
        .pid_vec  (pid_vec),
        .key_vpn  (lk_vaddr[VA_W-1:OFF_W]),
        .key_pid  (cur_pid),
        .tag_en   (pid_tag_en),
        .match_vec(match_vec)
    );

    tlb_prio #(.NUM_ENT(NUM_ENT)) u_prio (
        .req  (match_vec),
        .found(found),
        .idx  (sel_idx)
    );

    assign sel = ents[sel_idx];

    always_comb begin
        hit_int  = lk_valid && found && (!lk_write || sel.wr);
        lk_hit   = hit_int;
        lk_miss  = lk_valid && !found;
        lk_prot  = lk_valid && found && lk_write && !sel.wr;
        lk_paddr = hit_int ? {sel.frame, lk_vaddr[OFF_W-1:0]} : '0;
        lk_ref   = hit_int && sel.refd;
        lk_dirty = hit_int && sel.dirty;
    end

    tlb_store #(.NUM_ENT(NUM_ENT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (hit_int),
        .upd_idx  (sel_idx),
        .upd_write(lk_write),
        .flush    (flush),
        .rf_en    (rf_en),
        .rf_idx   (rf_idx),
        .rf_data  (rf_data),
        .ents     (ents)
    );

    assert_miss_no_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (match_vec == '0 && !lk_hit && !lk_prot));

    assert_prot_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_prot |-> (lk_write && !ents[sel_idx].wr && !lk_hit));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_prot));

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0] && $onehot0(match_vec & ~((match_vec - 1'b1) | match_vec) ) == 1'b1));
endmodule

// File: tb/tlb_fa_tb.sv
`timescale 1ns/1ps
module tlb_fa_tb;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0, pid_tag_en = 0, flush = 0;
    logic [23:0] lk_vaddr = '0;
    logic [7:0]  cur_pid = '0;
    logic        rf_en = 0, rf_dirty = 0, rf_ref = 0, rf_wr = 0, rf_valid = 0;
    logic [5:0]  rf_idx = '0;
    logic [10:0] rf_vpn = '0;
    logic [18:0] rf_frame = '0;
    logic [7:0]  rf_pid = '0;
    logic        lk_hit, lk_miss, lk_prot, lk_ref, lk_dirty;
    logic [31:0] lk_paddr;

    int tests = 0, fails = 0;

    // behavioural reference table
    bit       m_v[N], m_w[N], m_r[N], m_d[N];
    int       m_vpn[N], m_frm[N], m_pid[N];

    always #2.5 clk = ~clk;

    tlb_fa u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .cur_pid(cur_pid), .pid_tag_en(pid_tag_en),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_prot(lk_prot), .lk_paddr(lk_paddr),
        .lk_ref(lk_ref), .lk_dirty(lk_dirty), .rf_en(rf_en), .rf_idx(rf_idx),
        .rf_vpn(rf_vpn), .rf_frame(rf_frame), .rf_pid(rf_pid), .rf_dirty(rf_dirty),
        .rf_ref(rf_ref), .rf_wr(rf_wr), .rf_valid(rf_valid), .flush(flush)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        tests++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    // one cycle: check outputs against the model, then advance the model
    task automatic tick(input string req);
        bit e_hit = 0, e_miss = 0, e_prot = 0, e_r = 0, e_d = 0;
        bit [31:0] e_pa = '0;
        int sel = -1;
        #2;
        if (lk_valid) begin
            for (int i = 0; i < N; i++) begin
                if (sel < 0 && m_v[i] && m_vpn[i] == int'(lk_vaddr[23:13]) &&
                    (!pid_tag_en || m_pid[i] == int'(cur_pid))) sel = i;
            end
            if (sel < 0) e_miss = 1;
            else if (lk_write && !m_w[sel]) e_prot = 1;
            else begin
                e_hit = 1;
                e_pa  = {m_frm[sel][18:0], lk_vaddr[12:0]};
                e_r   = m_r[sel];
                e_d   = m_d[sel];
            end
        end
        tests++;
        if ({lk_hit, lk_miss, lk_prot, lk_ref, lk_dirty} !== {e_hit, e_miss, e_prot, e_r, e_d} ||
            lk_paddr !== e_pa) begin
            fails++;
            $display("FAIL %s: actual hit=%0b miss=%0b prot=%0b ref=%0b dirty=%0b pa=%h expected hit=%0b miss=%0b prot=%0b ref=%0b dirty=%0b pa=%h",
                     req, lk_hit, lk_miss, lk_prot, lk_ref, lk_dirty, lk_paddr,
                     e_hit, e_miss, e_prot, e_r, e_d, e_pa);
        end
        @(posedge clk);
        if (e_hit) begin
            m_r[sel] = 1;
            if (lk_write) m_d[sel] = 1;
        end
        if (flush) for (int i = 0; i < N; i++) m_v[i] = 0;
        if (rf_en) begin
            m_v[rf_idx] = rf_valid; m_w[rf_idx] = rf_wr; m_r[rf_idx] = rf_ref;
            m_d[rf_idx] = rf_dirty; m_vpn[rf_idx] = int'(rf_vpn);
            m_frm[rf_idx] = int'(rf_frame); m_pid[rf_idx] = int'(rf_pid);
        end
        @(negedge clk);
        rf_en = 0; flush = 0;
    endtask

    task automatic set_rf(input int idx, input int vpn, input int frm, input int pid,
                          input bit w, input bit v);
        rf_en = 1; rf_idx = 6'(idx); rf_vpn = 11'(vpn); rf_frame = 19'(frm);
        rf_pid = 8'(pid); rf_wr = w; rf_valid = v; rf_ref = 0; rf_dirty = 0;
    endtask

    task automatic look(input int vpn, input int off, input bit w);
        lk_valid = 1; lk_vaddr = {11'(vpn), 13'(off)}; lk_write = w;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_w[i] = 0; m_r[i] = 0; m_d[i] = 0;
            m_vpn[i] = 0; m_frm[i] = 0; m_pid[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;

        look(11'h123, 13'h456, 0); tick("R11 reset state miss");
        look(11'h000, 13'h000, 0); tick("R5 miss fault on empty table");

        // refill slot 5 while looking it up: old contents seen
        set_rf(5, 11'h2A1, 19'h4BCDE, 0, 1, 1);
        look(11'h2A1, 13'h1FFF, 0); tick("R6 same-cycle lookup sees old contents");
        look(11'h2A1, 13'h1FFF, 1); tick("R1 R2 write hit, offset passthrough");
        look(11'h2A1, 13'h0003, 0); tick("R9 ref and dirty now set");

        // read-only page
        set_rf(10, 11'h055, 19'h00077, 0, 0, 1); lk_valid = 0; tick("R10 idle during refill");
        look(11'h055, 13'h0010, 1); tick("R8 write to read-only page");
        look(11'h055, 13'h0010, 0); tick("R8 R9 prot fault left ref clear");

        // duplicates: lowest index wins
        set_rf(20, 11'h3C3, 19'h11111, 0, 1, 1); lk_valid = 0; tick("R3 fill high slot");
        set_rf(3, 11'h3C3, 19'h22222, 0, 1, 1);  lk_valid = 0; tick("R3 fill low slot");
        look(11'h3C3, 13'h0ABC, 0); tick("R3 lowest index supplies frame");

        // process tag
        set_rf(30, 11'h0F0, 19'h33333, 7, 1, 1); lk_valid = 0; tick("R4 fill tagged");
        pid_tag_en = 1; cur_pid = 7; look(11'h0F0, 13'h0001, 0); tick("R4 tag match hits");
        cur_pid = 8; look(11'h0F0, 13'h0001, 0); tick("R4 tag mismatch misses");
        pid_tag_en = 0; look(11'h0F0, 13'h0001, 0); tick("R4 tag ignored when off");

        // idle with matching address changes nothing
        set_rf(40, 11'h444, 19'h44444, 0, 1, 1); lk_valid = 0; tick("R6 fill slot 40");
        lk_valid = 0; lk_vaddr = {11'h444, 13'h0}; lk_write = 1; tick("R10 idle with match");
        look(11'h444, 13'h0002, 0); tick("R10 flags untouched after idle");

        // write hit and refill of the same slot in one cycle: refill wins
        set_rf(40, 11'h444, 19'h55555, 0, 1, 1);
        look(11'h444, 13'h0005, 1); tick("R6 write hit with same-slot refill");
        look(11'h444, 13'h0006, 0); tick("R6 refill overrode flag update");

        // flush together with refill
        set_rf(50, 11'h505, 19'h66666, 0, 1, 1); flush = 1;
        look(11'h2A1, 13'h0000, 0); tick("R7 flush cycle still sees old table");
        look(11'h2A1, 13'h0000, 0); tick("R7 flushed entry misses");
        look(11'h505, 13'h0123, 0); tick("R7 same-cycle refill survives flush");
        look(11'h3C3, 13'h0123, 0); tick("R7 other entries flushed");

        // mixed free-running phase
        for (int k = 0; k < 3000; k++) begin
            lk_valid = ($urandom_range(0, 7) != 0);
            lk_write = $urandom_range(0, 1);
            lk_vaddr = {11'($urandom_range(0, 11)), 13'($urandom)};
            pid_tag_en = $urandom_range(0, 1);
            cur_pid = 8'($urandom_range(0, 2));
            if ($urandom_range(0, 3) == 0)
                set_rf($urandom_range(0, N - 1), $urandom_range(0, 11), $urandom,
                       $urandom_range(0, 2), $urandom_range(0, 1), $urandom_range(0, 4) != 0);
            flush = ($urandom_range(0, 199) == 0);
            tick("R2 R9 mixed traffic");
        end

        summary();
    end
endmodule